// File: doc/BRIEF.md
# Multi-Set Vertical FIR Multiply-Accumulate Core

This core is the arithmetic heart of an eight-tap vertical image filter. Each clock it takes eight 12-bit two's complement samples, one per vertical tap, and multiplies each by a 12-bit coefficient. It then adds the eight products into one 32-bit sum. The coefficients come from one row of a 256-row store. Every row holds a complete set, one coefficient per tap. A registered row address picks the set, and that address changes only on cycles when its active-low enable is asserted. So a filter can switch sets per pixel or per line, or keep one set indefinitely.

An accumulate control lets a longer filter be formed over several cycles. While the control is high, each new sum is added into a running accumulator and the result register keeps its previous value. When the control is low, the accumulator restarts from the fresh sum and the result register loads that same sum. Both the accumulator and the result register are visible at the ports. Coefficients are written through a simple synchronous port that names a tap bank, a row and a value.

Top module: `vfir_mac`

## Requirements
- R1: Tap samples and coefficients are 12-bit two's complement. Tap k occupies bits [12k+11:12k] of `tap_i`. The sum equals the exact signed total of the eight tap-times-coefficient products, sign-extended to 32 bits.
- R2: `row_addr_i` is captured on a rising edge only when `row_addr_en_n` is 0. When it is 1, the held row is unchanged.
- R3: The held row selects one coefficient per tap: tap k is multiplied by row entry k, which lives in bank k.
- R4: When `cw_en` is 1 at a rising edge, `cw_data` is stored at bank `cw_bank` and row `cw_row`. Samples taken at any later edge use the new value.
- R5: If `acc_i` was 1 with a sample, the accumulator becomes its previous value plus that sample's sum, and `result_o` keeps its previous value.
- R6: If `acc_i` was 0 with a sample, `accum_o` and `result_o` both load that sample's sum, with no previous value added.
- R7: A sample presented with its controls at edge n appears on `result_o`/`accum_o` just after edge n+2. This fixed latency of three registered stages is the package constant `PIPE_LAT`.
- R8: Reset (`rst_n` = 0, asynchronous) clears `result_o`, `accum_o` and the pipeline, and sets the held row to 0.
- R9: Extreme operands do not overflow. Eight products of -2048 times -2048 give exactly 33554432, and eight products of -2048 times 2047 give exactly -33538048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_i | input | 96 | Eight packed 12-bit signed tap samples, tap 0 in the low bits |
| row_addr_i | input | 8 | Coefficient row address |
| row_addr_en_n | input | 1 | Active-low capture enable for the row address |
| acc_i | input | 1 | 1: add into accumulator and hold result; 0: load fresh sum |
| cw_en | input | 1 | Coefficient write strobe |
| cw_bank | input | 3 | Tap bank written |
| cw_row | input | 8 | Row written |
| cw_data | input | 12 | Signed coefficient value |
| result_o | output | 32 | Result register |
| accum_o | output | 32 | Running accumulator |

## Verification
The assertions assume that the address enable, address and accumulate control are known at every edge after reset. They also assume that reset is asserted from time zero, so that history before release is never consulted. The stimulus drives every control from a defined value at each falling edge and holds reset over the first edges. Accumulation chains are kept short, so that the 32-bit running sum never wraps and the model needs no wrap rule. Coefficients are only rewritten while no compared sample is in flight.

// File: rtl/vfir_pkg.sv
package vfir_pkg;
  localparam int TAPS     = 8;
  localparam int DW       = 12;
  localparam int CW       = 12;
  localparam int ROWS     = 256;
  localparam int ACCW     = 32;
  localparam int AW       = $clog2(ROWS);
  localparam int BW       = $clog2(TAPS);
  localparam int PW       = DW + CW;
  localparam int PIPE_LAT = 3;

  typedef logic signed [DW-1:0]   tap_t;
  typedef logic signed [CW-1:0]   coef_t;
  typedef logic signed [PW-1:0]   prod_t;
  typedef logic signed [ACCW-1:0] acc_t;
  typedef prod_t prod_vec_t [TAPS];
  typedef coef_t coef_vec_t [TAPS];

  // exact signed product of one tap and one coefficient
  function automatic prod_t tap_mul(input tap_t d, input coef_t c);
    prod_t dx, cx;
    dx = {{(PW-DW){d[DW-1]}}, d};
    cx = {{(PW-CW){c[CW-1]}}, c};
    return dx * cx;
  endfunction

  function automatic acc_t widen(input prod_t p);
    return {{(ACCW-PW){p[PW-1]}}, p};
  endfunction

  function automatic acc_t add_terms(input prod_vec_t p);
    acc_t s;
    s = '0;
    for (int k = 0; k < TAPS; k++) s = s + widen(p[k]);
    return s;
  endfunction
endpackage

// File: rtl/vfir_coef_store.sv
module vfir_coef_store
  import vfir_pkg::*;
(
  input  logic            clk,
  input  logic            wr_en,
  input  logic [BW-1:0]   wr_bank,
  input  logic [AW-1:0]   wr_row,
  input  logic [CW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_row,
  output coef_vec_t       rd_coefs
);
  for (genvar b = 0; b < TAPS; b++) begin : g_bank
    logic [CW-1:0] mem [ROWS];
    always_ff @(posedge clk) begin
      if (wr_en && wr_bank == BW'(b)) mem[wr_row] <= wr_data;
    end
    assign rd_coefs[b] = coef_t'(mem[rd_row]);
  end
endmodule

// File: rtl/vfir_row_reg.sv
module vfir_row_reg
  import vfir_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_n,
  input  logic [AW-1:0] row_i,
  output logic [AW-1:0] row_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     row_q <= '0;
    else if (!en_n) row_q <= row_i;
  end
endmodule

// File: rtl/vfir_mul_stage.sv
module vfir_mul_stage
  import vfir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAPS*DW-1:0] tap_flat,
  input  logic              acc_i,
  input  coef_vec_t         coefs,
  output prod_vec_t         prod_q,
  output logic              acc_q2
);
  tap_t tap_q [TAPS];
  logic acc_q1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) begin
        tap_q[k]  <= '0;
        prod_q[k] <= '0;
      end
      acc_q1 <= 1'b0;
      acc_q2 <= 1'b0;
    end else begin
      for (int k = 0; k < TAPS; k++) begin
        tap_q[k]  <= tap_t'(tap_flat[k*DW +: DW]);
        prod_q[k] <= tap_mul(tap_q[k], coefs[k]);
      end
      acc_q1 <= acc_i;
      acc_q2 <= acc_q1;
    end
  end
endmodule

// File: rtl/vfir_accum.sv
module vfir_accum
  import vfir_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  prod_vec_t prods,
  input  logic      acc_en,
  output acc_t      accum_q,
  output acc_t      result_q
);
  acc_t sum_w;
  always_comb sum_w = add_terms(prods);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accum_q  <= '0;
      result_q <= '0;
    end else if (acc_en) begin
      accum_q  <= accum_q + sum_w;
    end else begin
      accum_q  <= sum_w;
      result_q <= sum_w;
    end
  end
endmodule

// File: rtl/vfir_mac.sv
module vfir_mac
  import vfir_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TAPS*DW-1:0]   tap_i,
  input  logic [AW-1:0]        row_addr_i,
  input  logic                 row_addr_en_n,
  input  logic                 acc_i,
  input  logic                 cw_en,
  input  logic [BW-1:0]        cw_bank,
  input  logic [AW-1:0]        cw_row,
  input  logic [CW-1:0]        cw_data,
  output logic [ACCW-1:0]      result_o,
  output logic [ACCW-1:0]      accum_o
);
  logic [AW-1:0] row_q;      // held coefficient row
  coef_vec_t     row_coefs;
  prod_vec_t     prods;
  logic          acc_stage;  // accumulate flag aligned with the products
  acc_t          accum_w, result_w;

  vfir_row_reg u_row (
    .clk(clk), .rst_n(rst_n), .en_n(row_addr_en_n),
    .row_i(row_addr_i), .row_q(row_q)
  );

  vfir_coef_store u_store (
    .clk(clk), .wr_en(cw_en), .wr_bank(cw_bank), .wr_row(cw_row),
    .wr_data(cw_data), .rd_row(row_q), .rd_coefs(row_coefs)
  );

  vfir_mul_stage u_mul (
    .clk(clk), .rst_n(rst_n), .tap_flat(tap_i), .acc_i(acc_i),
    .coefs(row_coefs), .prod_q(prods), .acc_q2(acc_stage)
  );

  vfir_accum u_acc (
    .clk(clk), .rst_n(rst_n), .prods(prods), .acc_en(acc_stage),
    .accum_q(accum_w), .result_q(result_w)
  );

  assign result_o = result_w;
  assign accum_o  = accum_w;
endmodule

// File: rtl/vfir_mac_chk.sv
module vfir_mac_chk #(
  parameter int AW   = 8,
  parameter int ACCW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            row_addr_en_n,
  input logic [AW-1:0]   row_addr_i,
  input logic [AW-1:0]   row_q,
  input logic            acc_stage,
  input logic [ACCW-1:0] result_o,
  input logic [ACCW-1:0] accum_o
);
  a_r2_row_load: assert property (@(posedge clk) disable iff (!rst_n)
    !row_addr_en_n |=> row_q == $past(row_addr_i));

  a_r2_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    row_addr_en_n |=> $stable(row_q));

  a_r5_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stage |=> $stable(result_o));

  a_r6_fresh_match: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_stage |=> result_o == accum_o);

  a_r8_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (result_o == '0 && accum_o == '0 && row_q == '0));
endmodule

bind vfir_mac vfir_mac_chk #(.AW(vfir_pkg::AW), .ACCW(vfir_pkg::ACCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_addr_en_n(row_addr_en_n),
  .row_addr_i(row_addr_i), .row_q(row_q), .acc_stage(acc_stage),
  .result_o(result_o), .accum_o(accum_o)
);

// File: tb/vfir_mac_bench.sv
module vfir_mac_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] tap_i = '0;
  logic [7:0]  row_addr_i = '0;
  logic        row_addr_en_n = 1'b1;
  logic        acc_i = 1'b0;
  logic        cw_en = 1'b0;
  logic [2:0]  cw_bank = '0;
  logic [7:0]  cw_row = '0;
  logic [11:0] cw_data = '0;
  logic [31:0] result_o, accum_o;

  always #4 clk = ~clk;  // 125 MHz

  vfir_mac u_vfir_mac (
    .clk(clk), .rst_n(rst_n), .tap_i(tap_i), .row_addr_i(row_addr_i),
    .row_addr_en_n(row_addr_en_n), .acc_i(acc_i), .cw_en(cw_en),
    .cw_bank(cw_bank), .cw_row(cw_row), .cw_data(cw_data),
    .result_o(result_o), .accum_o(accum_o)
  );

  typedef struct {
    int          e;
    logic [31:0] res;
    logic [31:0] acc;
    string       tag;
  } exp_t;

  exp_t q[$];
  int compared = 0, mismatched = 0, edge_cnt = 0;
  int m_coef [8][256];
  int m_row = 0;
  logic [31:0] m_acc = '0, m_res = '0;
  bit done = 0;

  initial forever begin
    @(posedge clk);
    edge_cnt++;
  end

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what,
               $signed(act), $signed(exp));
    end
  endtask

  // monitor: pops items whose output edge has just passed
  initial forever begin
    @(posedge clk);
    #2;
    while (q.size() > 0 && q[0].e + 2 == edge_cnt) begin
      exp_t it;
      it = q.pop_front();
      check(it.tag, "result_o", result_o, it.res);
      check(it.tag, "accum_o", accum_o, it.acc);
    end
  end

  function automatic int cval(int b, int r);
    if (r == 255) return -2048;
    if (r == 254) return 2047;
    return ((b * 37 + r * 11 + 5) % 4096) - 2048;
  endfunction

  task automatic write_coef(int b, int r, int v);
    @(negedge clk);
    cw_en = 1'b1; cw_bank = 3'(b); cw_row = 8'(r); cw_data = 12'(v);
    m_coef[b][r] = v;
    @(negedge clk);
    cw_en = 1'b0;
  endtask

  // driver: presents one sample and pushes the expected outputs
  task automatic issue(input int t [8], int row, bit load, bit acc, string tag);
    longint s;
    exp_t it;
    @(negedge clk);
    for (int k = 0; k < 8; k++) tap_i[k*12 +: 12] = 12'(t[k]);
    row_addr_i = 8'(row); row_addr_en_n = !load; acc_i = acc;
    if (load) m_row = row;
    s = 0;
    for (int k = 0; k < 8; k++) s += longint'(t[k]) * longint'(m_coef[k][m_row]);
    if (acc) m_acc = m_acc + 32'(s);
    else begin
      m_acc = 32'(s);
      m_res = 32'(s);
    end
    it.e = edge_cnt + 1; it.res = m_res; it.acc = m_acc; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    row_addr_en_n = 1'b1; acc_i = 1'b0; row_addr_i = 8'hA5;
    repeat (n) @(negedge clk);
  endtask

  function automatic void pattern(int seed, output int t [8]);
    for (int k = 0; k < 8; k++) t[k] = ((seed * 97 + k * 613 + 41) % 4096) - 2048;
  endfunction

  initial begin
    #(200000 * 8);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int t [8];
    repeat (3) @(negedge clk);
    // R8: outputs cleared while reset is held
    check("R8", "result_o in reset", result_o, 32'd0);
    check("R8", "accum_o in reset", accum_o, 32'd0);
    for (int b = 0; b < 8; b++)
      for (int r = 0; r < 256; r++) begin
        cw_en = 1'b1; cw_bank = 3'(b); cw_row = 8'(r);
        cw_data = 12'(cval(b, r)); m_coef[b][r] = cval(b, r);
        @(negedge clk);
      end
    cw_en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "result_o after release", result_o, 32'd0);

    // R8/R7/R1/R3: first sample uses row 0 without loading
    pattern(1, t); issue(t, 200, 0, 0, "R8 row0");
    for (int i = 2; i < 6; i++) begin
      pattern(i, t); issue(t, i * 13, 1, 0, "R1 R3 R7 load");
    end
    // R2: enable high, address ignored
    for (int i = 6; i < 9; i++) begin
      pattern(i, t); issue(t, 250 - i, 0, 0, "R2 hold");
    end
    idle(4);

    // R5/R6: chain
    pattern(20, t); issue(t, 40, 1, 0, "R6 start");
    for (int i = 21; i < 24; i++) begin
      pattern(i, t); issue(t, i, 1, 1, "R5 accumulate");
    end
    pattern(30, t); issue(t, 41, 1, 0, "R6 fresh");
    pattern(31, t); issue(t, 41, 0, 1, "R5 hold");
    idle(4);

    // R9: extremes
    for (int k = 0; k < 8; k++) t[k] = -2048;
    issue(t, 255, 1, 0, "R9 max positive");
    issue(t, 254, 1, 0, "R9 max negative");
    idle(4);
    check("R9", "result_o extreme", result_o, -32'sd33538048);

    // R4: rewrite one coefficient, then use it
    write_coef(3, 7, -1000);
    write_coef(0, 7, 777);
    pattern(50, t); issue(t, 7, 1, 0, "R4 new coef");
    for (int k = 0; k < 8; k++) t[k] = (k == 3) ? 1 : 0;
    issue(t, 7, 0, 0, "R4 bank3 only");
    idle(5);
    check("R4", "result_o single tap", result_o, -32'sd1000);

    if (q.size() != 0) begin
      compared++; mismatched++;
      $display("FAIL R7: actual %0d pending expected 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule